// File: doc/BRIEF.md
# Audio Codec Register Access Controller

This block is the software-visible register file of an audio controller that talks to an external codec over a serial link. A processor reaches it through a 32-bit word bus on which only whole, aligned word accesses count. The block holds four words that set up a single codec register access: control, target address, outgoing data and returned data. It also holds two groups of three words, one for the playback DMA channel and one for the capture DMA channel.

Software starts a codec register access by writing the control word with its request bit set. The block never keeps that bit: the stored copy always reads back with bit 0 clear. The direction bit picks which of two interrupt lines gives a single one-cycle pulse. One line starts an outgoing (write) transaction and the other announces that read data is ready. These pulses stand in for the serial framing engine, which lives elsewhere. The enable bit of each DMA control word is brought out as a level that the DMA engines follow.

Top module: `ac_codec_regs`

## Requirements
- R1: After reset every readable word returns 0, both DMA enable outputs are 0 and both interrupt outputs are 0.
- R2: Word index = byte address shifted right by two. Indices 0 to 10 are, in order: codec control, codec address, codec data-out, codec data-in, playback control, playback address, playback remaining, a reserved word, capture control, capture address, capture remaining. Except for codec control, every non-reserved index returns on read the last full-word value written to it.
- R3: A read request produces `rd_valid` high with the read data on `rd_data` in the cycle after the request, for one cycle.
- R4: A write to codec control stores the written value with bit 0 forced to 0.
- R5: A write to codec control with bit 0 = 1 and bit 1 = 1 drives `irq_request` high for exactly the one cycle after the write, with `irq_reply` low.
- R6: A write to codec control with bit 0 = 1 and bit 1 = 0 drives `irq_reply` high for exactly the one cycle after the write, with `irq_request` low.
- R7: A write to codec control with bit 0 = 0 pulses neither interrupt, whatever bit 1 holds.
- R8: The reserved word (index 7) and every index of 11 or more read as 0, and writes to them change no stored word.
- R9: An access with `bus_be` other than 4'hF, or with address bits [1:0] not zero, is ignored. A write changes nothing and fires no interrupt, and a read returns 0.
- R10: `dn_enable` follows bit 0 of playback control and `up_enable` follows bit 0 of capture control, each changing in the cycle after the write.
- R11: Requests on consecutive cycles each give their own pulse, and the two interrupt lines are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 32 | Read data |
| irq_request | output | 1 | One-cycle pulse: outgoing codec write requested |
| irq_reply | output | 1 | One-cycle pulse: codec read requested |
| dn_enable | output | 1 | Playback DMA enable |
| up_enable | output | 1 | Capture DMA enable |

## Verification
The bench targets the self-clearing request bit. A design that stored bit 0 would read back odd values and would let a rewrite of the same word fire again. Writes of the control word with the request bit clear but the direction bit set catch a design that decodes direction alone and pulses anyway. Back-to-back requests in both directions catch a pulse generator that stretches pulses or swallows the second one. Accesses to the reserved word, to indices past the map, with partial byte enables and with misaligned addresses catch decode that aliases onto a real register or lets a narrow write through.

// File: rtl/ac_pkg.sv
package ac_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_WORDS = 11;
    localparam int IDX_CC    = 0;   // codec control
    localparam int IDX_RSV   = 7;   // reserved hole
    localparam int IDX_DNC   = 4;   // playback control
    localparam int IDX_UPC   = 8;   // capture control
    localparam int BIT_REQ   = 0;
    localparam int BIT_DIR   = 1;

    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/ac_decode.sv
module ac_decode #(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output logic [IDX_W-1:0]  idx,
    output logic              hit
);
    import ac_pkg::*;

    logic legal_shape;
    logic in_map;

    always_comb begin
        idx         = addr[ADDR_W-1:2];
        legal_shape = (be == 4'hF) && (addr[1:0] == 2'b00);
        in_map      = (idx < IDX_W'(NUM_WORDS)) && (idx != IDX_W'(IDX_RSV));
        hit         = legal_shape && in_map;
    end
endmodule

// File: rtl/ac_irq_pulse.sv
module ac_irq_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic dir_wr,
    output logic pulse_req,
    output logic pulse_rep
);
    typedef struct packed {
        logic req;
        logic rep;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d.req = fire &&  dir_wr;
        p_d.rep = fire && !dir_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign pulse_req = p_q.req;
    assign pulse_rep = p_q.rep;
endmodule

// File: rtl/ac_codec_regs.sv
module ac_codec_regs #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              irq_request,
    output logic              irq_reply,
    output logic              dn_enable,
    output logic              up_enable
);
    import ac_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] regs;
        logic [DATA_W-1:0]                rdat;
        logic                             rvld;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0] acc_idx;
    logic             acc_hit;
    logic             req_fire;

    ac_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .be   (bus_be),
        .idx  (acc_idx),
        .hit  (acc_hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rvld = bus_valid && !bus_we;
        st_d.rdat = '0;
        req_fire  = 1'b0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (bus_valid && acc_hit && (acc_idx == IDX_W'(i))) begin
                if (bus_we) begin
                    if (i == IDX_CC) begin
                        st_d.regs[i]          = bus_wdata;
                        st_d.regs[i][BIT_REQ] = 1'b0;
                        req_fire              = bus_wdata[BIT_REQ];
                    end else begin
                        st_d.regs[i] = bus_wdata;
                    end
                end else begin
                    st_d.rdat = st_q.regs[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ac_irq_pulse u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (req_fire),
        .dir_wr    (bus_wdata[BIT_DIR]),
        .pulse_req (irq_request),
        .pulse_rep (irq_reply)
    );

    assign rd_valid  = st_q.rvld;
    assign rd_data   = st_q.rdat;
    assign dn_enable = st_q.regs[IDX_DNC][0];
    assign up_enable = st_q.regs[IDX_UPC][0];
endmodule

// File: rtl/ac_codec_regs_chk.sv
module ac_codec_regs_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic              rd_valid,
    input logic              irq_request,
    input logic              irq_reply,
    input logic              dn_enable,
    input logic              up_enable
);
    logic full_wr;
    assign full_wr = bus_valid && bus_we && (bus_be == 4'hF);

    // R5
    req_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_request |-> $past(full_wr && bus_addr == '0 && bus_wdata[1:0] == 2'b11));

    // R6
    rep_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_reply |-> $past(full_wr && bus_addr == '0 && bus_wdata[1:0] == 2'b01));

    // R7
    no_req_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && bus_addr == '0 && !bus_wdata[0]) |=> (!irq_request && !irq_reply));

    // R11
    irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_request && irq_reply));

    // R3
    rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_valid && !bus_we));

    // R10
    dn_en_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dn_enable) |-> $past(full_wr && bus_addr == ADDR_W'(16)));

    // R10
    up_en_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(up_enable) |-> $past(full_wr && bus_addr == ADDR_W'(32)));
endmodule

bind ac_codec_regs ac_codec_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .irq_request(irq_request), .irq_reply(irq_reply),
    .dn_enable(dn_enable), .up_enable(up_enable)
);

// File: tb/ac_codec_regs_bench.sv
`timescale 1ns/1ps
module ac_codec_regs_bench;
    localparam int AW = 8;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          bus_valid = 0, bus_we = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [3:0]    bus_be = '0;
    logic [31:0]   bus_wdata = '0;
    logic          rd_valid, irq_request, irq_reply, dn_enable, up_enable;
    logic [31:0]   rd_data;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] mdl [11];

    always #2 clk = ~clk;

    ac_codec_regs #(.ADDR_W(AW)) u_ac_codec_regs (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq_request(irq_request),
        .irq_reply(irq_reply), .dn_enable(dn_enable), .up_enable(up_enable)
    );

    function automatic bit acc_ok(input logic [AW-1:0] a, input logic [3:0] be);
        int idx = int'(a >> 2);
        return (be == 4'hF) && (a[1:0] == 2'b00) && (idx < 11) && (idx != 7);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [AW-1:0] a, input logic [3:0] be);
        return acc_ok(a, be) ? mdl[int'(a >> 2)] : 32'h0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        bit ok = acc_ok(a, be);
        bit fire = ok && (a == 0) && d[0];
        @(negedge clk);
        bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_valid = 0; bus_we = 0;
        if (ok) begin
            mdl[int'(a >> 2)] = d;
            if (a == 0) mdl[0][0] = 1'b0;   // R4 self clear
        end
        chk("R5", {31'b0, irq_request}, {31'b0, fire && d[1]});
        chk("R6", {31'b0, irq_reply}, {31'b0, fire && !d[1]});
        chk("R10", {30'b0, dn_enable, up_enable}, {30'b0, mdl[4][0], mdl[8][0]});
        @(negedge clk);
        chk("R5/R6 single cycle", {30'b0, irq_request, irq_reply}, 32'h0);
    endtask

    task automatic rd(input string req, input logic [AW-1:0] a, input logic [3:0] be);
        @(negedge clk);
        bus_valid = 1; bus_we = 0; bus_addr = a; bus_be = be;
        @(negedge clk);
        bus_valid = 0;
        chk("R3", {31'b0, rd_valid}, 32'h1);
        chk(req, rd_data, exp_rd(a, be));
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        foreach (mdl[i]) mdl[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {28'b0, irq_request, irq_reply, dn_enable, up_enable}, 32'h0);
        chk("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
        rst_n = 1;
        for (int i = 0; i < 16; i++) rd("R1", AW'(i * 4), 4'hF);

        // R2 fill map, R8 reserved/out of range
        for (int i = 0; i < 11; i++) wr(AW'(i * 4), 32'hA5000000 | 32'(i * 3 + 2), 4'hF);
        wr(AW'(28), 32'hDEADBEEF, 4'hF);
        wr(AW'(44), 32'h12345678, 4'hF);
        wr(AW'(60), 32'h87654321, 4'hF);
        for (int i = 0; i < 16; i++) rd("R2/R8", AW'(i * 4), 4'hF);

        // R4..R7 directed
        wr(0, 32'h3, 4'hF); rd("R4", 0, 4'hF);
        wr(0, 32'h1, 4'hF); rd("R4", 0, 4'hF);
        wr(0, 32'h2, 4'hF); rd("R7", 0, 4'hF);
        wr(0, 32'hFFFFFFFE, 4'hF); rd("R4", 0, 4'hF);

        // R9 narrow and misaligned
        wr(0, 32'h3, 4'h3);
        wr(AW'(17), 32'h1, 4'hF);
        wr(AW'(16), 32'h1, 4'h1);
        rd("R9", AW'(4), 4'h7);
        rd("R9", AW'(6), 4'hF);

        // R10 enables
        wr(AW'(16), 32'h1, 4'hF); wr(AW'(32), 32'h1, 4'hF);
        wr(AW'(16), 32'h0, 4'hF); wr(AW'(32), 32'h0, 4'hF);

        // R11 back to back requests
        @(negedge clk);
        bus_valid = 1; bus_we = 1; bus_addr = 0; bus_be = 4'hF; bus_wdata = 32'h3;
        @(negedge clk);
        bus_wdata = 32'h1;
        chk("R11 first", {30'b0, irq_request, irq_reply}, 32'h2);
        @(negedge clk);
        bus_valid = 0; bus_we = 0;
        chk("R11 second", {30'b0, irq_request, irq_reply}, 32'h1);
        @(negedge clk);
        chk("R11 idle", {30'b0, irq_request, irq_reply}, 32'h0);
        mdl[0] = 32'h0;

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] a;
            logic [3:0]    be;
            logic [31:0]   d;
            a  = AW'($urandom_range(0, 15) * 4);
            if ($urandom_range(0, 9) == 0) a = a | AW'($urandom_range(1, 3));
            be = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
            d  = $urandom;
            if ($urandom_range(0, 3) == 0) d[1:0] = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 1) wr(a, d, be);
            else rd("R2 random", a, be);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule